// File: doc/BRIEF.md
# Masked Trigger OR with Per-Channel Rate Counters

This block sits behind a bank of eighteen discriminators. It produces two fast trigger proposals. The low trigger is the OR of channels 8..0 and the high trigger is the OR of channels 17..9. In each group only the channels whose mask bit is clear take part, so a noisy channel can be silenced without touching the others. The raw hit lines are asynchronous. Each one passes through a two-flop synchroniser before any use.

Every channel also has its own hit counter. It counts rising edges over a window whose width is picked by a 2-bit code. When a window closes, all counters are copied into a held bank and restart from zero. A controller reads one held value at a time by channel index. The controller can also route any single synchronised channel to a monitor pin and read back the mask it last wrote.

Top module: `trig_or_ratemon`

## Requirements
- R1: `trig_lo` equals the OR of synchronised hits 8..0 with mask bits clear, and `trig_hi` the same for hits 17..9. Both follow `hit_raw` three clock edges after the input changes.
- R2: A channel whose mask bit is 1 never asserts its group trigger. A channel whose mask bit is 0 can always assert it.
- R3: `mask_wr` stores `mask_wdata[17:0]` at that edge, and `mask_wdata[23:18]` are ignored. A `mask_rd` pulse loads the stored mask into `mask_rdata` at the next edge. Without a read strobe, `mask_rdata` holds its value.
- R4: `mon_out` shows the synchronised level of channel `mon_sel`, three edges after `hit_raw` changes, whatever the mask. Any `mon_sel` of 18 or more gives 0.
- R5: Every low-to-high transition on a hit line adds exactly one to that channel's count, whatever the mask. A pulse must be at least one clock high and at least one clock low.
- R6: Window code `win_sel` = 0, 1, 2, 3 gives windows of WIN_BASE × 1, 10, 100 and 1000 clocks. With the default WIN_BASE at 10 MHz these are 1 ms, 10 ms, 100 ms and 1 s. When a window ends, every count moves to the held bank and the counters clear. A change of `win_sel` starts a fresh window and clears the counters, but leaves the held bank unchanged.
- R7: A counter stops at 2^CNT_W−1 and never wraps.
- R8: A `cnt_rd` pulse loads the held count of channel `cnt_sel` into `cnt_rdata` at the next edge. Any `cnt_sel` of 18 or more gives 0.
- R9: While `rst_n` is low, all outputs are 0 and the mask is cleared, so every channel is unmasked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 10 MHz system clock |
| rst_n | input | 1 | synchronous active-low reset |
| hit_raw | input | 18 | asynchronous discriminator hit lines |
| mask_wr | input | 1 | mask write strobe |
| mask_wdata | input | 24 | three-byte mask word, bit = 1 masks the channel |
| mask_rd | input | 1 | mask readback strobe |
| mask_rdata | output | 18 | last mask read back |
| win_sel | input | 2 | counting window code |
| mon_sel | input | 5 | monitor channel index |
| mon_out | output | 1 | selected synchronised hit level |
| cnt_rd | input | 1 | count readback strobe |
| cnt_sel | input | 5 | channel index for count readback |
| cnt_rdata | output | CNT_W | held count of the selected channel |
| trig_lo | output | 1 | OR of unmasked channels 8..0 |
| trig_hi | output | 1 | OR of unmasked channels 17..9 |

## Verification
The two triggers and the monitor pin become valid three rising edges after a change on `hit_raw`: two synchroniser stages and one output register. The vector loop therefore changes the inputs on a falling edge, waits three rising edges and samples on the following falling edge. Mask and count readbacks are due one edge after their strobe and are sampled on the next falling edge. For window checks, the bench counts edges from the one that restarts the window and reads the held bank a couple of edges after the computed close. It also reads once at mid-window, where the previous window's value must still be present.

// File: rtl/trig_rate_pkg.sv
// Shared helpers for the masked trigger OR and rate counter block.
// Assumes window codes 0..3 scale a base length by successive powers of ten.
package trig_rate_pkg;

    // Window length in clocks for a 2-bit code.
    function automatic logic [31:0] win_cycles(input logic [31:0] base, input logic [1:0] code);
        logic [31:0] len;
        case (code)
            2'd0:    len = base;
            2'd1:    len = base * 32'd10;
            2'd2:    len = base * 32'd100;
            default: len = base * 32'd1000;
        endcase
        return len;
    endfunction

endpackage

// File: rtl/hit_sync.sv
// Two-flop synchroniser and rising-edge detector for a bank of hit lines.
// Assumes each pulse is at least one clock high and one clock low.
module hit_sync #(
    parameter int N_CH = 18
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] raw,
    output logic [N_CH-1:0] level,
    output logic [N_CH-1:0] rise
);
    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        logic s1, s2, s3;
        // Resynchronise the raw line and keep one delayed copy for edge finding.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
                s3 <= 1'b0;
            end else begin
                s1 <= raw[i];
                s2 <= s1;
                s3 <= s2;
            end
        end
        assign level[i] = s2;
        assign rise[i]  = s2 & ~s3;
    end
endmodule

// File: rtl/group_or.sv
// Registered OR of unmasked channels, one output per group of GRP channels.
// Assumes N_CH is a whole multiple of GRP; lowest group drives bit 0.
module group_or #(
    parameter int N_CH = 18,
    parameter int GRP  = 9,
    localparam int N_GRP = N_CH / GRP
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_CH-1:0]  level,
    input  logic [N_CH-1:0]  mask,
    output logic [N_GRP-1:0] trig
);
    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        // Combine the unmasked members of this group into one trigger bit.
        always_ff @(posedge clk) begin
            if (!rst_n) trig[g] <= 1'b0;
            else        trig[g] <= |(level[g*GRP +: GRP] & ~mask[g*GRP +: GRP]);
        end
    end
endmodule

// File: rtl/win_timer.sv
// Counting window timer: pulses win_end on the last clock of each window and
// flags restart for one clock whenever the window code changes.
// Assumes WIN_BASE * 1000 fits in TW bits.
module win_timer
    import trig_rate_pkg::*;
#(
    parameter int WIN_BASE = 10000,
    localparam int TW = $clog2(WIN_BASE * 1000 + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] win_sel,
    output logic       win_end,
    output logic       restart
);
    logic [1:0]    sel_q;
    logic [TW-1:0] tmr;
    logic [31:0]   limit;

    // Decode the terminal count for the active code and detect a code change.
    always_comb begin
        limit   = win_cycles(32'(WIN_BASE), sel_q) - 32'd1;
        restart = (win_sel != sel_q);
        win_end = !restart && (32'(tmr) == limit);
    end

    // Advance the timer, returning to zero on window end or code change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= 2'd0;
            tmr   <= '0;
        end else begin
            sel_q <= win_sel;
            if (restart || win_end) tmr <= '0;
            else                    tmr <= tmr + 1'b1;
        end
    end
endmodule

// File: rtl/rate_counters.sv
// Per-channel saturating edge counters with a held bank updated at window end.
// Assumes restart and win_end never need to act together (restart wins).
module rate_counters #(
    parameter int N_CH  = 18,
    parameter int CNT_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_CH-1:0]            rise,
    input  logic                       win_end,
    input  logic                       restart,
    output logic [N_CH-1:0][CNT_W-1:0] cnt,
    output logic [N_CH-1:0][CNT_W-1:0] held
);
    for (genvar i = 0; i < N_CH; i++) begin : g_cnt
        logic [CNT_W-1:0] nxt;
        // Add this clock's edge unless the counter is already full.
        always_comb begin
            nxt = cnt[i];
            if (rise[i] && cnt[i] != '1) nxt = cnt[i] + 1'b1;
        end
        // Count, clear on restart, or move into the held bank at window end.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt[i]  <= '0;
                held[i] <= '0;
            end else if (restart) begin
                cnt[i]  <= '0;
            end else if (win_end) begin
                held[i] <= nxt;
                cnt[i]  <= '0;
            end else begin
                cnt[i]  <= nxt;
            end
        end
    end
endmodule

// File: rtl/trig_or_ratemon.sv
// Top: two masked group triggers, a monitor multiplexer, windowed per-channel
// hit counting and mask/count readback. Assumes hit_raw is asynchronous and
// all strobes are synchronous one-clock pulses.
module trig_or_ratemon #(
    parameter int N_CH     = 18,
    parameter int GRP      = 9,
    parameter int CNT_W    = 16,
    parameter int WIN_BASE = 10000,
    localparam int SEL_W   = $clog2(N_CH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_CH-1:0]  hit_raw,
    input  logic             mask_wr,
    input  logic [23:0]      mask_wdata,
    input  logic             mask_rd,
    output logic [N_CH-1:0]  mask_rdata,
    input  logic [1:0]       win_sel,
    input  logic [SEL_W-1:0] mon_sel,
    output logic             mon_out,
    input  logic             cnt_rd,
    input  logic [SEL_W-1:0] cnt_sel,
    output logic [CNT_W-1:0] cnt_rdata,
    output logic             trig_lo,
    output logic             trig_hi
);
    logic [N_CH-1:0]            hit_lvl;
    logic [N_CH-1:0]            hit_rise;
    logic [N_CH-1:0]            mask_q;
    logic [1:0]                 trig;
    logic                       win_end;
    logic                       restart;
    logic [N_CH-1:0][CNT_W-1:0] cnt_q;
    logic [N_CH-1:0][CNT_W-1:0] held_q;

    hit_sync #(.N_CH(N_CH)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw(hit_raw), .level(hit_lvl), .rise(hit_rise)
    );

    group_or #(.N_CH(N_CH), .GRP(GRP)) u_or (
        .clk(clk), .rst_n(rst_n), .level(hit_lvl), .mask(mask_q), .trig(trig)
    );

    win_timer #(.WIN_BASE(WIN_BASE)) u_tmr (
        .clk(clk), .rst_n(rst_n), .win_sel(win_sel), .win_end(win_end), .restart(restart)
    );

    rate_counters #(.N_CH(N_CH), .CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .rise(hit_rise), .win_end(win_end),
        .restart(restart), .cnt(cnt_q), .held(held_q)
    );

    assign trig_lo = trig[0];
    assign trig_hi = trig[1];

    // Store the mask; the upper byte bits beyond the channel count are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_wr) mask_q <= mask_wdata[N_CH-1:0];
    end

    // Register the mask readback on its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_rdata <= '0;
        else if (mask_rd) mask_rdata <= mask_q;
    end

    // Route the selected synchronised channel to the monitor pin.
    always_ff @(posedge clk) begin
        if (!rst_n)                      mon_out <= 1'b0;
        else if (32'(mon_sel) < N_CH)    mon_out <= hit_lvl[mon_sel];
        else                             mon_out <= 1'b0;
    end

    // Register the held count of the selected channel on its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)                    cnt_rdata <= '0;
        else if (cnt_rd) begin
            if (32'(cnt_sel) < N_CH)   cnt_rdata <= held_q[cnt_sel];
            else                       cnt_rdata <= '0;
        end
    end
endmodule

// File: rtl/trig_or_ratemon_chk.sv
// Property checker for trig_or_ratemon, attached with bind.
module trig_or_ratemon_chk #(
    parameter int N_CH  = 18,
    parameter int GRP   = 9,
    parameter int CNT_W = 16,
    parameter int SEL_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_CH-1:0]  mask_q,
    input logic             trig_lo,
    input logic             trig_hi,
    input logic [SEL_W-1:0] mon_sel,
    input logic             mon_out,
    input logic             mask_rd,
    input logic [N_CH-1:0]  mask_rdata,
    input logic [CNT_W-1:0] cnt0,
    input logic             win_end,
    input logic             restart
);
    a_r2_lo_group_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_q[GRP-1:0]) |=> !trig_lo);
    a_r2_hi_group_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_q[N_CH-1:GRP]) |=> !trig_hi);
    a_r4_mon_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(mon_sel) >= N_CH) |=> !mon_out);
    a_r3_mask_readback: assert property (@(posedge clk) disable iff (!rst_n)
        mask_rd |=> (mask_rdata == $past(mask_q)));
    a_r3_readback_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_rd |=> $stable(mask_rdata));
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt0 == '1) && !win_end && !restart) |=> (cnt0 == '1));
endmodule

bind trig_or_ratemon trig_or_ratemon_chk #(
    .N_CH(N_CH), .GRP(GRP), .CNT_W(CNT_W), .SEL_W(SEL_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .mask_q(mask_q), .trig_lo(trig_lo), .trig_hi(trig_hi),
    .mon_sel(mon_sel), .mon_out(mon_out), .mask_rd(mask_rd), .mask_rdata(mask_rdata),
    .cnt0(cnt_q[0]), .win_end(win_end), .restart(restart)
);

// File: tb/trig_or_ratemon_bench.sv
// Bench: vector table for triggers/monitor, then directed counting tests.
module trig_or_ratemon_bench;
    localparam int CLK_PERIOD = 100;
    localparam int N_CH  = 18;
    localparam int CNT_W = 6;
    localparam int BASE  = 20;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [N_CH-1:0]   hit_raw;
    logic              mask_wr, mask_rd, cnt_rd;
    logic [23:0]       mask_wdata;
    logic [N_CH-1:0]   mask_rdata;
    logic [1:0]        win_sel;
    logic [4:0]        mon_sel, cnt_sel;
    logic              mon_out, trig_lo, trig_hi;
    logic [CNT_W-1:0]  cnt_rdata;

    int checks = 0, fails = 0, cyc = 0, e0 = 0;
    bit done = 1'b0;

    trig_or_ratemon #(.N_CH(N_CH), .GRP(9), .CNT_W(CNT_W), .WIN_BASE(BASE)) u_trig_or_ratemon (
        .clk(clk), .rst_n(rst_n), .hit_raw(hit_raw), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
        .mask_rd(mask_rd), .mask_rdata(mask_rdata), .win_sel(win_sel), .mon_sel(mon_sel),
        .mon_out(mon_out), .cnt_rd(cnt_rd), .cnt_sel(cnt_sel), .cnt_rdata(cnt_rdata),
        .trig_lo(trig_lo), .trig_hi(trig_hi)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct packed {
        logic [17:0] hits;
        logic [17:0] mask;
        logic [4:0]  sel;
        logic        lo;
        logic        hi;
        logic        mon;
    } vec_t;

    localparam vec_t VEC [9] = '{
        '{18'h00000, 18'h00000, 5'd0,  1'b0, 1'b0, 1'b0},
        '{18'h00001, 18'h00000, 5'd0,  1'b1, 1'b0, 1'b1},
        '{18'h00200, 18'h00000, 5'd9,  1'b0, 1'b1, 1'b1},
        '{18'h00100, 18'h00100, 5'd8,  1'b0, 1'b0, 1'b1},
        '{18'h20000, 18'h00000, 5'd17, 1'b0, 1'b1, 1'b1},
        '{18'h3FFFF, 18'h3FFFF, 5'd5,  1'b0, 1'b0, 1'b1},
        '{18'h3FFFF, 18'h3FE00, 5'd20, 1'b1, 1'b0, 1'b0},
        '{18'h00600, 18'h00200, 5'd4,  1'b0, 1'b1, 1'b0},
        '{18'h001FF, 18'h000FF, 5'd0,  1'b1, 1'b0, 1'b1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_edge(input int n);
        while (cyc < n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic restart_win(input logic [1:0] code);
        @(negedge clk);
        win_sel = code;
        @(posedge clk);
        #1;
        e0 = cyc;
        @(negedge clk);
    endtask

    task automatic pulse(input int ch, input int n);
        for (int k = 0; k < n; k++) begin
            hit_raw[ch] = 1'b1;
            @(negedge clk);
            hit_raw[ch] = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic read_cnt(input logic [4:0] ch);
        cnt_sel = ch;
        cnt_rd  = 1'b1;
        @(negedge clk);
        cnt_rd  = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog R1..R9 actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; hit_raw = '0; mask_wr = 1'b0; mask_rd = 1'b0; cnt_rd = 1'b0;
        mask_wdata = '0; win_sel = 2'd0; mon_sel = '0; cnt_sel = '0;
        repeat (4) @(negedge clk);
        // R9: reset state
        chk("R9 trig_lo", 32'(trig_lo), 0);
        chk("R9 trig_hi", 32'(trig_hi), 0);
        chk("R9 mon_out", 32'(mon_out), 0);
        chk("R9 mask_rdata", 32'(mask_rdata), 0);
        chk("R9 cnt_rdata", 32'(cnt_rdata), 0);
        rst_n = 1'b1;
        mask_rd = 1'b1;
        @(negedge clk);
        mask_rd = 1'b0;
        chk("R9 mask cleared", 32'(mask_rdata), 0);

        // R1 R2 R4: vector table walk
        foreach (VEC[v]) begin
            mask_wdata = {6'h3F, VEC[v].mask};
            mask_wr    = 1'b1;
            hit_raw    = VEC[v].hits;
            mon_sel    = VEC[v].sel;
            @(negedge clk);
            mask_wr = 1'b0;
            repeat (2) @(negedge clk);
            chk($sformatf("R1 R2 trig_lo vec%0d", v), 32'(trig_lo), 32'(VEC[v].lo));
            chk($sformatf("R1 R2 trig_hi vec%0d", v), 32'(trig_hi), 32'(VEC[v].hi));
            chk($sformatf("R4 mon_out vec%0d", v), 32'(mon_out), 32'(VEC[v].mon));
        end
        hit_raw = '0;

        // R3: upper write bits dropped, readback, hold without strobe
        mask_wdata = 24'hFC0155; mask_wr = 1'b1;
        @(negedge clk);
        mask_wr = 1'b0; mask_rd = 1'b1;
        @(negedge clk);
        mask_rd = 1'b0;
        chk("R3 mask readback", 32'(mask_rdata), 32'h00155);
        mask_wdata = 24'h000ABC; mask_wr = 1'b1;
        @(negedge clk);
        mask_wr = 1'b0;
        @(negedge clk);
        chk("R3 readback holds", 32'(mask_rdata), 32'h00155);

        // R5 R8: counting in a 200-clock window
        restart_win(2'd1);
        pulse(3, 5);
        pulse(12, 2);
        wait_edge(e0 + 10 * BASE + 2);
        read_cnt(5'd3);
        chk("R5 count ch3", 32'(cnt_rdata), 5);
        read_cnt(5'd12);
        chk("R5 count ch12", 32'(cnt_rdata), 2);
        read_cnt(5'd25);
        chk("R8 out-of-range count", 32'(cnt_rdata), 0);

        // R6: code change keeps held bank; 2000-clock window length
        restart_win(2'd2);
        pulse(3, 3);
        wait_edge(e0 + 50 * BASE);
        read_cnt(5'd3);
        chk("R6 held kept mid-window", 32'(cnt_rdata), 5);
        wait_edge(e0 + 100 * BASE + 2);
        read_cnt(5'd3);
        chk("R6 held after window", 32'(cnt_rdata), 3);
        wait_edge(e0 + 200 * BASE + 2);
        read_cnt(5'd3);
        chk("R6 cleared next window", 32'(cnt_rdata), 0);

        // R7: saturation at 2^CNT_W-1
        restart_win(2'd1);
        pulse(7, 70);
        wait_edge(e0 + 10 * BASE + 2);
        read_cnt(5'd7);
        chk("R7 saturated count", 32'(cnt_rdata), 63);
        read_cnt(5'd8);
        chk("R5 idle channel", 32'(cnt_rdata), 0);

        // R6: shortest window
        restart_win(2'd0);
        pulse(1, 1);
        wait_edge(e0 + BASE + 2);
        read_cnt(5'd1);
        chk("R6 short window count", 32'(cnt_rdata), 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule